// File: doc/BRIEF.md
# Integer Operate Execute Unit

This block executes the register-to-register integer operate instructions of a 64-bit RISC core. It accepts one 32-bit instruction word at a time on a valid/ready input stream. It reads its two source operands from a built-in 32-entry register file and computes the result. The result is written back to the destination register on the same clock edge that accepts the instruction. The result, the destination index, the write flag and an illegal-instruction flag are also offered on a valid/ready output stream. Two major opcodes are decoded. Opcode 0x10 covers 32-bit and 64-bit add, subtract, the scaled add and subtract forms and the compares. Opcode 0x11 covers the bitwise logic operations and the conditional moves.

The input is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output slot is empty or is being drained in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the output holds its values and no new instruction is accepted. Each accepted instruction yields exactly one output beat, one cycle after acceptance. Register 31 reads as zero and can never be written.

Top module: `intop_exec_unit`

## Requirements
- R1: Instruction fields are taken from fixed positions: major opcode [31:26], source A index [25:21], source B index [20:16], literal select [12], function code [11:5] and destination index [4:0]. When bit 12 is 1, operand B is the zero-extended 8-bit literal from bits [20:13] instead of the register.
- R2: Register 31 reads as zero. An instruction whose destination is 31 reports `out_wen`=0 and changes no register.
- R3: Opcode 0x10, function 0x00 adds the low 32 bits of A and B and sign-extends the 32-bit sum to 64 bits.
- R4: Opcode 0x10 computes 64-bit results as follows, all modulo 2^64: 0x20 gives A+B, 0x29 gives A-B, 0x22 gives 4A+B, 0x2B gives 4A-B, 0x32 gives 8A+B and 0x3B gives 8A-B.
- R5: The opcode 0x10 compares give exactly 1 when true and 0 otherwise: 0x2D tests A==B, 0x1D tests unsigned A<B, 0x3D tests unsigned A<=B, 0x4D tests signed A<B and 0x6D tests signed A<=B.
- R6: Opcode 0x11 logic: 0x00 gives A&B, 0x08 gives A&~B, 0x20 gives A|B, 0x28 gives A|~B, 0x40 gives A^B and 0x48 gives A^~B.
- R7: An opcode 0x11 conditional move reports B as the result and writes it only when its test on A holds. The tests are: 0x14 A[0]=1, 0x16 A[0]=0, 0x24 A==0, 0x26 A!=0, 0x44 A<0, 0x46 A>=0, 0x64 A<=0, 0x66 A>0 (all signed). When the test fails, `out_wen`=0 and the destination keeps its old value.
- R8: An unlisted function code, or any major opcode other than 0x10 and 0x11, sets `out_illegal`=1, `out_wen`=0 and `out_result`=0, and changes no register.
- R9: `in_ready` = !`out_valid` || `out_ready`. While the output is stalled, every output stays stable.
- R10: After reset, `out_valid` is 0 and every register reads as zero.
- R11: A register written by an accepted instruction supplies the new value to the very next accepted instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction can be accepted |
| in_instr | input | 32 | Instruction word |
| out_valid | output | 1 | Result beat available |
| out_ready | input | 1 | Consumer takes the result beat |
| out_result | output | 64 | Computed result |
| out_dest | output | 5 | Destination register index |
| out_wen | output | 1 | The destination register was written |
| out_illegal | output | 1 | Instruction was not recognised |

## Verification
The bench targets several corner cases, and each one exposes a specific kind of design error.

- A 32-bit add whose sum crosses bit 31 must sign-extend. A design that zero-extends, or that keeps a 64-bit sum, returns a positive or oversized value.
- Signed and unsigned compares are checked on operands with opposite top bits. A design that mixes up signedness reports the inverse answer.
- Conditional moves whose test fails are followed by a read-back of the destination. A design that writes anyway shows the moved value there.
- Writes to register 31 are followed by a read of register 31. Reading it must return zero.
- A stall with a second instruction waiting shows whether the output drifts or the waiting instruction is swallowed.

// File: rtl/intop_pkg.sv
package intop_pkg;
  localparam int XLEN   = 64;
  localparam int NREGS  = 32;
  localparam int LITW   = 8;
  localparam int FUNCW  = 7;

  localparam logic [5:0] OPC_ARITH = 6'h10;
  localparam logic [5:0] OPC_LOGIC = 6'h11;

  // arithmetic group
  localparam logic [FUNCW-1:0] FN_ADD32  = 7'h00;
  localparam logic [FUNCW-1:0] FN_LTU    = 7'h1D;
  localparam logic [FUNCW-1:0] FN_ADD    = 7'h20;
  localparam logic [FUNCW-1:0] FN_ADD_X4 = 7'h22;
  localparam logic [FUNCW-1:0] FN_SUB    = 7'h29;
  localparam logic [FUNCW-1:0] FN_SUB_X4 = 7'h2B;
  localparam logic [FUNCW-1:0] FN_EQ     = 7'h2D;
  localparam logic [FUNCW-1:0] FN_ADD_X8 = 7'h32;
  localparam logic [FUNCW-1:0] FN_SUB_X8 = 7'h3B;
  localparam logic [FUNCW-1:0] FN_LEU    = 7'h3D;
  localparam logic [FUNCW-1:0] FN_LTS    = 7'h4D;
  localparam logic [FUNCW-1:0] FN_LES    = 7'h6D;

  // logic group
  localparam logic [FUNCW-1:0] FN_AND     = 7'h00;
  localparam logic [FUNCW-1:0] FN_ANDN    = 7'h08;
  localparam logic [FUNCW-1:0] FN_MV_ODD  = 7'h14;
  localparam logic [FUNCW-1:0] FN_MV_EVEN = 7'h16;
  localparam logic [FUNCW-1:0] FN_OR      = 7'h20;
  localparam logic [FUNCW-1:0] FN_MV_ZERO = 7'h24;
  localparam logic [FUNCW-1:0] FN_MV_NZ   = 7'h26;
  localparam logic [FUNCW-1:0] FN_ORN     = 7'h28;
  localparam logic [FUNCW-1:0] FN_XOR     = 7'h40;
  localparam logic [FUNCW-1:0] FN_MV_NEG  = 7'h44;
  localparam logic [FUNCW-1:0] FN_MV_NNEG = 7'h46;
  localparam logic [FUNCW-1:0] FN_XNOR    = 7'h48;
  localparam logic [FUNCW-1:0] FN_MV_NPOS = 7'h64;
  localparam logic [FUNCW-1:0] FN_MV_POS  = 7'h66;

  typedef struct packed {
    logic [XLEN-1:0] value;
    logic            wr;
    logic            known;
  } unit_out_t;
endpackage

// File: rtl/intop_regfile.sv
module intop_regfile #(
  parameter int XW = intop_pkg::XLEN,
  parameter int NR = intop_pkg::NREGS,
  localparam int AW = $clog2(NR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_a_idx,
  input  logic [AW-1:0] rd_b_idx,
  output logic [XW-1:0] rd_a_val,
  output logic [XW-1:0] rd_b_val,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [XW-1:0] wr_val
);
  localparam logic [AW-1:0] ZREG = AW'(NR - 1);

  logic [XW-1:0] store [NR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NR; i++) store[i] <= '0;
    end else if (wr_en && wr_idx != ZREG) begin
      store[wr_idx] <= wr_val;
    end
  end

  assign rd_a_val = (rd_a_idx == ZREG) ? '0 : store[rd_a_idx];
  assign rd_b_val = (rd_b_idx == ZREG) ? '0 : store[rd_b_idx];
endmodule

// File: rtl/intop_arith.sv
module intop_arith
  import intop_pkg::*;
#(
  parameter int XW = XLEN,
  localparam int HW = XW / 2
) (
  input  logic [XW-1:0]    a,
  input  logic [XW-1:0]    b,
  input  logic [FUNCW-1:0] func,
  output logic [XW-1:0]    value,
  output logic             known
);
  logic [HW-1:0] sum_lo;
  logic [XW-1:0] a_x4, a_x8;

  assign sum_lo = a[HW-1:0] + b[HW-1:0];
  assign a_x4   = a << 2;
  assign a_x8   = a << 3;

  always_comb begin
    known = 1'b1;
    value = '0;
    unique case (func)
      FN_ADD32:  value = {{(XW-HW){sum_lo[HW-1]}}, sum_lo};
      FN_ADD:    value = a + b;
      FN_SUB:    value = a - b;
      FN_ADD_X4: value = a_x4 + b;
      FN_SUB_X4: value = a_x4 - b;
      FN_ADD_X8: value = a_x8 + b;
      FN_SUB_X8: value = a_x8 - b;
      FN_EQ:     value = XW'(a == b);
      FN_LTU:    value = XW'(a < b);
      FN_LEU:    value = XW'(a <= b);
      FN_LTS:    value = XW'($signed(a) < $signed(b));
      FN_LES:    value = XW'($signed(a) <= $signed(b));
      default:   known = 1'b0;
    endcase
  end
endmodule

// File: rtl/intop_logic.sv
module intop_logic
  import intop_pkg::*;
#(
  parameter int XW = XLEN
) (
  input  logic [XW-1:0]    a,
  input  logic [XW-1:0]    b,
  input  logic [FUNCW-1:0] func,
  output logic [XW-1:0]    value,
  output logic             wr,
  output logic             known
);
  logic a_neg, a_zero;

  assign a_neg  = a[XW-1];
  assign a_zero = (a == '0);

  always_comb begin
    known = 1'b1;
    wr    = 1'b1;
    value = b;
    unique case (func)
      FN_AND:     value = a & b;
      FN_ANDN:    value = a & ~b;
      FN_OR:      value = a | b;
      FN_ORN:     value = a | ~b;
      FN_XOR:     value = a ^ b;
      FN_XNOR:    value = a ^ ~b;
      FN_MV_ODD:  wr = a[0];
      FN_MV_EVEN: wr = ~a[0];
      FN_MV_ZERO: wr = a_zero;
      FN_MV_NZ:   wr = ~a_zero;
      FN_MV_NEG:  wr = a_neg;
      FN_MV_NNEG: wr = ~a_neg;
      FN_MV_NPOS: wr = a_neg | a_zero;
      FN_MV_POS:  wr = ~a_neg & ~a_zero;
      default: begin
        known = 1'b0;
        wr    = 1'b0;
        value = '0;
      end
    endcase
  end
endmodule

// File: rtl/intop_exec_unit.sv
module intop_exec_unit
  import intop_pkg::*;
#(
  parameter int XW = XLEN,
  parameter int NR = NREGS,
  parameter int LW = LITW,
  localparam int AW = $clog2(NR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [31:0]   in_instr,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [XW-1:0] out_result,
  output logic [AW-1:0] out_dest,
  output logic          out_wen,
  output logic          out_illegal
);
  localparam logic [AW-1:0] ZREG = AW'(NR - 1);

  // field extraction
  logic [5:0]       f_opc;
  logic [AW-1:0]    f_ra, f_rb, f_rc;
  logic             f_use_lit;
  logic [LW-1:0]    f_lit;
  logic [FUNCW-1:0] f_func;

  assign f_opc     = in_instr[31:26];
  assign f_ra      = in_instr[21 +: AW];
  assign f_rb      = in_instr[16 +: AW];
  assign f_use_lit = in_instr[12];
  assign f_lit     = in_instr[13 +: LW];
  assign f_func    = in_instr[5 +: FUNCW];
  assign f_rc      = in_instr[0 +: AW];

  logic [XW-1:0] ra_val, rb_val, opnd_b;
  logic          accept, rf_we;
  unit_out_t     nxt;

  intop_regfile #(.XW(XW), .NR(NR)) rf_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_a_idx (f_ra),
    .rd_b_idx (f_rb),
    .rd_a_val (ra_val),
    .rd_b_val (rb_val),
    .wr_en    (rf_we),
    .wr_idx   (f_rc),
    .wr_val   (nxt.value)
  );

  assign opnd_b = f_use_lit ? {{(XW-LW){1'b0}}, f_lit} : rb_val;

  logic [XW-1:0] ar_val, lg_val;
  logic          ar_known, lg_known, lg_wr;

  intop_arith #(.XW(XW)) arith_i (
    .a(ra_val), .b(opnd_b), .func(f_func), .value(ar_val), .known(ar_known)
  );

  intop_logic #(.XW(XW)) logic_i (
    .a(ra_val), .b(opnd_b), .func(f_func), .value(lg_val), .wr(lg_wr),
    .known(lg_known)
  );

  logic is_ar, is_lg;
  assign is_ar = (f_opc == OPC_ARITH);
  assign is_lg = (f_opc == OPC_LOGIC);

  always_comb begin
    nxt.known = (is_ar && ar_known) || (is_lg && lg_known);
    nxt.value = !nxt.known ? '0 : (is_ar ? ar_val : lg_val);
    nxt.wr    = nxt.known && (is_ar || lg_wr) && (f_rc != ZREG);
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign rf_we    = accept && nxt.wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_dest    <= '0;
      out_wen     <= 1'b0;
      out_illegal <= 1'b0;
    end else if (accept) begin
      out_valid   <= 1'b1;
      out_result  <= nxt.value;
      out_dest    <= f_rc;
      out_wen     <= nxt.wr;
      out_illegal <= !nxt.known;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/intop_exec_unit_chk.sv
module intop_exec_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [31:0] in_instr,
  input logic        out_valid,
  input logic        out_ready,
  input logic [63:0] out_result,
  input logic [4:0]  out_dest,
  input logic        out_wen,
  input logic        out_illegal
);
  logic cap_cmp, cap_ar;
  logic [6:0] fn;
  assign fn = in_instr[11:5];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_cmp <= 1'b0;
      cap_ar  <= 1'b0;
    end else if (in_valid && in_ready) begin
      cap_ar  <= (in_instr[31:26] == 6'h10);
      cap_cmp <= (in_instr[31:26] == 6'h10) &&
                 (fn == 7'h1D || fn == 7'h2D || fn == 7'h3D ||
                  fn == 7'h4D || fn == 7'h6D);
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) &&
    $stable(out_dest) && $stable(out_wen) && $stable(out_illegal));

  assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_zero_dest_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_dest == 5'd31 |-> !out_wen);

  assert_bad_nowrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> !out_wen && out_result == 64'd0);

  assert_cmp_bool_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cap_cmp |-> out_result[63:1] == 63'd0);

  assert_arith_writes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cap_ar && !out_illegal && out_dest != 5'd31 |-> out_wen);
endmodule

bind intop_exec_unit intop_exec_unit_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_instr(in_instr), .out_valid(out_valid), .out_ready(out_ready),
  .out_result(out_result), .out_dest(out_dest), .out_wen(out_wen),
  .out_illegal(out_illegal)
);

// File: tb/intop_exec_unit_tb_top.sv
`timescale 1ns/1ps
module intop_exec_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_instr = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_result;
  logic [4:0]  out_dest;
  logic        out_wen;
  logic        out_illegal;

  int checks = 0;
  int errors = 0;
  logic [63:0] m [32];

  always #5 clk = ~clk;

  intop_exec_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_dest(out_dest), .out_wen(out_wen),
    .out_illegal(out_illegal)
  );

  function automatic logic [31:0] enc(input logic [5:0] op, input int ra,
                                      input int rb, input logic [6:0] fn, input int rc);
    return {op, 5'(ra), 5'(rb), 4'b0000, fn, 5'(rc)};
  endfunction

  function automatic logic [31:0] encl(input logic [5:0] op, input int ra,
                                       input logic [7:0] lit, input logic [6:0] fn, input int rc);
    return {op, 5'(ra), lit, 1'b1, fn, 5'(rc)};
  endfunction

  function automatic void model(input logic [31:0] ins, output logic [63:0] res,
                                output logic wen, output logic ill, output string tag);
    logic [63:0] a, b;
    logic [31:0] s;
    logic ok, cond, mv;
    a = m[ins[25:21]];
    b = ins[12] ? {56'd0, ins[20:13]} : m[ins[20:16]];
    ok = 1'b1; mv = 1'b0; cond = 1'b1; res = 64'd0; tag = "R6";
    if (ins[31:26] == 6'h10) begin
      tag = "R4";
      case (ins[11:5])
        7'h00: begin s = a[31:0] + b[31:0]; res = {{32{s[31]}}, s}; tag = "R3"; end
        7'h20: res = a + b;
        7'h29: res = a - b;
        7'h22: res = a * 4 + b;
        7'h2B: res = a * 4 - b;
        7'h32: res = a * 8 + b;
        7'h3B: res = a * 8 - b;
        7'h2D: begin res = {63'd0, a == b}; tag = "R5"; end
        7'h1D: begin res = {63'd0, a < b}; tag = "R5"; end
        7'h3D: begin res = {63'd0, a <= b}; tag = "R5"; end
        7'h4D: begin res = {63'd0, $signed(a) < $signed(b)}; tag = "R5"; end
        7'h6D: begin res = {63'd0, $signed(a) <= $signed(b)}; tag = "R5"; end
        default: ok = 1'b0;
      endcase
    end else if (ins[31:26] == 6'h11) begin
      case (ins[11:5])
        7'h00: res = a & b;
        7'h08: res = a & ~b;
        7'h20: res = a | b;
        7'h28: res = a | ~b;
        7'h40: res = a ^ b;
        7'h48: res = ~(a ^ b);
        7'h14: begin mv = 1; cond = a[0]; end
        7'h16: begin mv = 1; cond = !a[0]; end
        7'h24: begin mv = 1; cond = (a == 0); end
        7'h26: begin mv = 1; cond = (a != 0); end
        7'h44: begin mv = 1; cond = $signed(a) < 0; end
        7'h46: begin mv = 1; cond = $signed(a) >= 0; end
        7'h64: begin mv = 1; cond = $signed(a) <= 0; end
        7'h66: begin mv = 1; cond = $signed(a) > 0; end
        default: ok = 1'b0;
      endcase
      if (mv) begin res = b; tag = "R7"; end
    end else ok = 1'b0;
    if (!ok) begin res = 64'd0; tag = "R8"; end
    ill = !ok;
    wen = ok && cond && (ins[4:0] != 5'd31);
    if (ok && ins[4:0] == 5'd31) tag = "R2";
  endfunction

  task automatic check_out(input logic [31:0] ins, input string tag);
    logic [63:0] er; logic ew, ei; string t;
    model(ins, er, ew, ei, t);
    if (tag == "") tag = t;
    checks++;
    if (!(out_valid && out_result == er && out_dest == ins[4:0] &&
          out_wen == ew && out_illegal == ei)) begin
      errors++;
      $display("FAIL %s instr=%h: got v=%b res=%h dst=%0d wen=%b ill=%b exp v=1 res=%h dst=%0d wen=%b ill=%b",
               tag, ins, out_valid, out_result, out_dest, out_wen, out_illegal,
               er, ins[4:0], ew, ei);
    end
    if (ew) m[ins[4:0]] = er;
  endtask

  task automatic run_op(input logic [31:0] ins, input string tag);
    @(negedge clk);
    in_instr = ins; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_out(ins, tag);
  endtask

  task automatic expect_val(input int r, input logic [63:0] v, input string tag);
    run_op(enc(6'h11, r, 31, 7'h20, 0), tag);
    checks++;
    if (out_result !== v) begin
      errors++;
      $display("FAIL %s reg %0d: got %h exp %h", tag, r, out_result, v);
    end
  endtask

  // R1 R11: builds a full 64-bit value with literals and dependent ops
  task automatic load_reg(input int r, input logic [63:0] v);
    run_op(encl(6'h11, 31, v[63:56], 7'h20, r), "R1");
    for (int i = 6; i >= 0; i--) begin
      run_op(encl(6'h10, r, 8'd0, 7'h32, r), "R11");
      run_op(encl(6'h10, r, 8'd0, 7'h32, r), "R11");
      run_op(enc(6'h10, r, r, 7'h20, r), "R11");
      run_op(enc(6'h10, r, r, 7'h20, r), "R11");
      run_op(encl(6'h11, r, v[i*8 +: 8], 7'h20, r), "R1");
    end
  endtask

  localparam logic [6:0] AR_FN [12] = '{7'h00, 7'h1D, 7'h20, 7'h22, 7'h29, 7'h2B,
                                         7'h2D, 7'h32, 7'h3B, 7'h3D, 7'h4D, 7'h6D};
  localparam logic [6:0] LG_FN [14] = '{7'h00, 7'h08, 7'h14, 7'h16, 7'h20, 7'h24, 7'h26,
                                         7'h28, 7'h40, 7'h44, 7'h46, 7'h48, 7'h64, 7'h66};

  initial begin
    #(1_000_000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] x;
    void'($urandom(32'd1234));
    for (int i = 0; i < 32; i++) m[i] = 64'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R10 after reset: got v=%b rdy=%b exp v=0 rdy=1", out_valid, in_ready);
    end
    expect_val(7, 64'd0, "R10");
    expect_val(30, 64'd0, "R10");

    load_reg(1, 64'h0000_0000_7FFF_FFFF);
    load_reg(2, 64'h8000_0000_0000_0001);
    load_reg(3, 64'hFFFF_FFFF_FFFF_FFFF);
    load_reg(4, 64'h0123_4567_89AB_CDEF);

    // R3: 32-bit sum crossing bit 31
    run_op(encl(6'h10, 1, 8'd1, 7'h00, 5), "R3");
    expect_val(5, 64'hFFFF_FFFF_8000_0000, "R3");
    // R4 scaled forms
    run_op(enc(6'h10, 4, 2, 7'h22, 6), "R4");
    run_op(enc(6'h10, 4, 2, 7'h3B, 6), "R4");
    // R5 signed vs unsigned with opposite top bits
    run_op(enc(6'h10, 2, 1, 7'h1D, 8), "R5");
    run_op(enc(6'h10, 2, 1, 7'h4D, 8), "R5");
    run_op(enc(6'h10, 3, 3, 7'h6D, 8), "R5");
    run_op(enc(6'h10, 3, 31, 7'h3D, 8), "R5");
    // R6
    run_op(enc(6'h11, 4, 3, 7'h48, 9), "R6");
    run_op(enc(6'h11, 4, 2, 7'h08, 9), "R6");
    // R7 not taken then read-back
    run_op(encl(6'h11, 31, 8'h55, 7'h20, 10), "R7");
    run_op(enc(6'h11, 4, 3, 7'h24, 10), "R7");
    expect_val(10, 64'h55, "R7");
    run_op(enc(6'h11, 2, 3, 7'h66, 10), "R7");
    expect_val(10, 64'h55, "R7");
    run_op(enc(6'h11, 2, 3, 7'h44, 10), "R7");
    expect_val(10, 64'hFFFF_FFFF_FFFF_FFFF, "R7");
    // R2 write to register 31
    run_op(enc(6'h10, 4, 3, 7'h20, 31), "R2");
    expect_val(31, 64'd0, "R2");
    // R8 bad function and bad opcode, register unchanged
    run_op(enc(6'h11, 4, 4, 7'h01, 10), "R8");
    run_op(enc(6'h12, 4, 4, 7'h20, 10), "R8");
    expect_val(10, 64'hFFFF_FFFF_FFFF_FFFF, "R8");

    // R9 stall with a second instruction waiting
    @(negedge clk);
    x = enc(6'h10, 4, 1, 7'h29, 11);
    in_instr = x; in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    in_instr = enc(6'h10, 11, 11, 7'h20, 12);
    checks++;
    if (in_ready !== 1'b0) begin
      errors++; $display("FAIL R9 in_ready during stall: got %b exp 0", in_ready);
    end
    @(negedge clk);
    check_out(x, "R9");
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_out(enc(6'h10, 11, 11, 7'h20, 12), "R9");

    // random mix
    for (int n = 0; n < 500; n++) begin
      logic [31:0] r;
      logic [6:0] fn;
      logic [5:0] op;
      r = $urandom;
      op = r[0] ? 6'h11 : 6'h10;
      fn = op == 6'h10 ? AR_FN[$urandom % 12] : LG_FN[$urandom % 14];
      if ($urandom % 20 == 0) fn = 7'h7F;
      if ($urandom % 30 == 0) op = 6'h13;
      if (r[1]) run_op(encl(op, $urandom % 32, 8'($urandom), fn, $urandom % 32), "");
      else      run_op(enc(op, $urandom % 32, $urandom % 32, fn, $urandom % 32), "");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule